// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block erases a run of whole pages in a serial page-organised flash device. The caller gives a first page index, a number of pages and the device's page-field shift. The block then works through the range one step at a time. Each step sends one four-byte erase command. After the command it polls the device status until the ready bit is set. If the current page sits on an eight-page boundary and at least eight pages are still to be erased, the step erases a whole block of eight pages. Otherwise it erases one page.

The block never touches bits on the wire. It drives a byte-wide request port that a separate SPI master serves. Each byte carries a hold flag, and that flag tells the master whether to keep chip select asserted after the byte. Between unsuccessful status polls the block waits a programmable number of idle cycles. The caller only ever supplies page indices, so byte-level alignment is settled before the request reaches this block.

Top module: `flash_erase_seq`

The controller has seven states:
- ST_IDLE: waits for `start`. With a zero count it goes to ST_DONE, otherwise to ST_CMD.
- ST_CMD: sends the four command bytes. It moves on after the fourth acknowledge.
- ST_POLL_OP: sends the status opcode. It moves on after the acknowledge.
- ST_POLL_RD: sends a dummy byte and samples the reply. If the device is ready it goes to ST_ADV. If not, it goes to ST_GAP, or straight back to ST_POLL_OP when the gap is zero.
- ST_GAP: idles for the gap, then returns to ST_POLL_OP.
- ST_ADV: steps the page index and the remaining count. It goes to ST_DONE when the count reaches zero, otherwise to ST_CMD.
- ST_DONE: lasts one cycle, then returns to ST_IDLE.

## Requirements
- R1: After reset `busy`, `done` and `spi_req` are all 0.
- R2: A step uses block erase (opcode 0x50) when the current page index has bits [2:0] equal to zero and at least 8 pages remain. Every other step uses page erase (opcode 0x81).
- R3: The device address is the page index shifted left by 8 + `page_shift_sel`. The command transaction is exactly four bytes, in this order: opcode, address[23:16], address[15:8], 0x00. The first three bytes have hold 1 and the last has hold 0.
- R4: After each command the block runs status transactions. Each is byte 0xD7 with hold 1, then 0x00 with hold 0, and the reply to the second byte is the status. The block repeats these until status bit 7 is 1, so one step performs exactly (not-ready replies + 1) polls.
- R5: A block step advances the page index by 8 and lowers the remaining count by 8. A page step changes each by 1. The remaining count never rises while busy.
- R6: When the remaining count reaches zero, `done` is 1 for exactly one cycle and `busy` is 0 from that cycle on. A start with a count of zero gives the same pulse and sends no bytes.
- R7: A `start` pulse while `busy` is 1 is ignored. The range, shift and gap in use do not change.
- R8: After a not-ready status reply, `spi_req` stays 0 for exactly `poll_gap` cycles (latched at start) before the next 0xD7 request. With a gap of zero the next request follows at once.
- R9: While `spi_req` is 1 and not yet acknowledged, `spi_byte` and `spi_hold` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an erase run (sampled only when idle) |
| start_page | input | PAGE_W | First page index |
| page_count | input | CNT_W | Number of pages to erase |
| page_shift_sel | input | 2 | Page-field shift minus 8 |
| poll_gap | input | GAP_W | Idle cycles between status polls |
| spi_req | output | 1 | Byte transfer request |
| spi_byte | output | 8 | Byte to send |
| spi_hold | output | 1 | Keep chip select asserted after this byte |
| spi_ack | input | 1 | One-cycle acknowledge, byte transfer complete |
| spi_rx | input | 8 | Byte received during the acknowledged transfer |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Some internal faults show at the ports within one transaction:
- A wrong byte index or state decode gives a command of the wrong length or a misplaced hold flag.
- A bad alignment test or address shift gives a mismatched opcode or address byte in the very next command.

A stepping or count error may first appear only as an extra, missing or shifted command later in the run. It always shows by `done` at the latest, because the expected command list is then not fully consumed. A gap counter that is off by one shows on the first not-ready poll, as a wrong count of idle cycles.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OP_STATUS_RD   = 8'hD7;
    localparam int         BLOCK_PAGES    = 8;
    localparam int         READY_BIT      = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL_OP,
        ST_POLL_RD,
        ST_GAP,
        ST_ADV,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/erase_step_plan.sv
module erase_step_plan
    import flash_erase_pkg::*;
#(
    parameter int PAGE_W = 16,
    parameter int CNT_W  = 17
) (
    input  logic [PAGE_W-1:0] page_idx,
    input  logic [CNT_W-1:0]  pages_left,
    input  logic [1:0]        shift_sel,
    output logic              use_block,
    output logic [CNT_W-1:0]  step_pages,
    output logic [7:0]        opcode,
    output logic [7:0]        addr_hi,
    output logic [7:0]        addr_mid
);
    localparam int ALIGN_BITS = $clog2(BLOCK_PAGES);

    // Address bits [23:8] equal the page index shifted by (shift - 8).
    logic [15:0] addr_upper;

    always_comb begin
        use_block  = (page_idx[ALIGN_BITS-1:0] == '0) &&
                     (pages_left >= CNT_W'(BLOCK_PAGES));
        step_pages = use_block ? CNT_W'(BLOCK_PAGES) : CNT_W'(1);
        opcode     = use_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
        addr_upper = 16'(page_idx) << shift_sel;
        addr_hi    = addr_upper[15:8];
        addr_mid   = addr_upper[7:0];
    end

endmodule

// File: rtl/poll_gap_timer.sv
module poll_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [GAP_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (run && remain_q != '0) begin
            remain_q <= remain_q - GAP_W'(1);
        end
    end

    assign expired = (remain_q <= GAP_W'(1));

    // R8: the timer only runs after a non-zero load.
    p_gap_loaded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> remain_q != '0);

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int PAGE_W = 16,
    parameter int CNT_W  = 17,
    parameter int GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] start_page,
    input  logic [CNT_W-1:0]  page_count,
    input  logic [1:0]        page_shift_sel,
    input  logic [GAP_W-1:0]  poll_gap,
    output logic              spi_req,
    output logic [7:0]        spi_byte,
    output logic              spi_hold,
    input  logic              spi_ack,
    input  logic [7:0]        spi_rx,
    output logic              busy,
    output logic              done
);
    localparam int CMD_BYTES = 4;

    seq_state_t        state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]  left_q;
    logic [1:0]        sel_q;
    logic [GAP_W-1:0]  gap_q;
    logic [1:0]        idx_q;

    logic              use_block;
    logic [CNT_W-1:0]  step_pages;
    logic [7:0]        opcode, addr_hi, addr_mid;
    logic              gap_load, gap_expired;
    logic              dev_ready;

    erase_step_plan #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_plan (
        .page_idx   (page_q),
        .pages_left (left_q),
        .shift_sel  (sel_q),
        .use_block  (use_block),
        .step_pages (step_pages),
        .opcode     (opcode),
        .addr_hi    (addr_hi),
        .addr_mid   (addr_mid)
    );

    assign gap_load  = (state_q == ST_POLL_RD) && spi_ack && !dev_ready;
    assign dev_ready = spi_rx[READY_BIT];

    poll_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_q),
        .run      (state_q == ST_GAP),
        .expired  (gap_expired)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = (page_count == '0) ? ST_DONE : ST_CMD;
            ST_CMD:     if (spi_ack && idx_q == 2'(CMD_BYTES - 1)) state_d = ST_POLL_OP;
            ST_POLL_OP: if (spi_ack) state_d = ST_POLL_RD;
            ST_POLL_RD: if (spi_ack) begin
                            if (dev_ready)         state_d = ST_ADV;
                            else if (gap_q == '0)  state_d = ST_POLL_OP;
                            else                   state_d = ST_GAP;
                        end
            ST_GAP:     if (gap_expired) state_d = ST_POLL_OP;
            ST_ADV:     state_d = (left_q == step_pages) ? ST_DONE : ST_CMD;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and step datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            left_q  <= '0;
            sel_q   <= '0;
            gap_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                page_q <= start_page;
                left_q <= page_count;
                sel_q  <= page_shift_sel;
                gap_q  <= poll_gap;
                idx_q  <= '0;
            end
            if (state_q == ST_CMD && spi_ack) begin
                idx_q <= idx_q + 2'd1;
            end
            if (state_q == ST_ADV) begin
                page_q <= page_q + PAGE_W'(step_pages);
                left_q <= left_q - step_pages;
            end
        end
    end

    // Outputs
    always_comb begin
        spi_req  = 1'b0;
        spi_byte = 8'h00;
        spi_hold = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_CMD: begin
                spi_req = 1'b1;
                unique case (idx_q)
                    2'd0: spi_byte = opcode;
                    2'd1: spi_byte = addr_hi;
                    2'd2: spi_byte = addr_mid;
                    default: spi_byte = 8'h00;
                endcase
                spi_hold = (idx_q != 2'(CMD_BYTES - 1));
            end
            ST_POLL_OP: begin
                spi_req  = 1'b1;
                spi_byte = OP_STATUS_RD;
                spi_hold = 1'b1;
            end
            ST_POLL_RD: spi_req = 1'b1;
            ST_GAP, ST_ADV: ;
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    p_req_in_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> busy);

    p_block_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && idx_q == 2'd0 && state_q == ST_CMD && spi_byte == OP_BLOCK_ERASE)
        |-> (page_q[2:0] == 3'd0 && left_q >= CNT_W'(BLOCK_PAGES)));

    p_reply_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL_RD && spi_ack) |-> !$isunknown(spi_rx));

    p_left_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> left_q <= $past(left_q));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_byte_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> spi_req && $stable(spi_byte) && $stable(spi_hold));

endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_page = '0;
    logic [16:0] page_count = '0;
    logic [1:0]  page_shift_sel = '0;
    logic [15:0] poll_gap = '0;
    logic        spi_req, spi_hold, spi_ack = 1'b0;
    logic [7:0]  spi_byte, spi_rx = 8'h00;
    logic        busy, done;

    int checks = 0, fails = 0;
    logic [23:0] expq[$];
    logic [7:0]  tbytes[$];
    int busyk = 0, exp_gap = 0, polls = 0, seen_cmd = 0, lat = 0;

    always #10 clk = ~clk;

    flash_erase_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
        .page_count(page_count), .page_shift_sel(page_shift_sel),
        .poll_gap(poll_gap), .spi_req(spi_req), .spi_byte(spi_byte),
        .spi_hold(spi_hold), .spi_ack(spi_ack), .spi_rx(spi_rx),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_txn(input logic [7:0] rx);
        if (tbytes[0] == 8'hD7) begin
            check(tbytes.size() == 2, "R4 poll length", tbytes.size(), 2);
            check(tbytes[tbytes.size()-1] == 8'h00, "R4 poll dummy", tbytes[tbytes.size()-1], 0);
            polls++;
            if (!rx[7]) begin : gap_count
                int cnt = 0;
                while (!spi_req) begin
                    cnt++;
                    @(negedge clk);
                end
                check(cnt == exp_gap, "R8 poll gap", cnt, exp_gap);
            end
        end else begin
            if (seen_cmd != 0) check(polls == busyk + 1, "R4 polls per step", polls, busyk + 1);
            seen_cmd = 1;
            polls = 0;
            check(tbytes.size() == 4, "R3 command length", tbytes.size(), 4);
            if (expq.size() == 0) begin
                check(0, "R7 unexpected command", tbytes[0], 0);
            end else begin : cmp
                logic [23:0] e = expq.pop_front();
                check({tbytes[0], tbytes[1], tbytes[2]} == e, "R2/R3 command",
                      {tbytes[0], tbytes[1], tbytes[2]}, e);
                check(tbytes[tbytes.size()-1] == 8'h00, "R3 trailing byte", tbytes[tbytes.size()-1], 0);
            end
        end
        tbytes.delete();
    endtask

    // Responder and monitor: serves the byte port and scores transactions.
    initial begin : responder
        logic [7:0] b, rx;
        logic h;
        forever begin
            @(negedge clk);
            if (spi_req) begin
                b = spi_byte;
                h = spi_hold;
                repeat (lat) begin
                    @(negedge clk);
                    check(spi_req && spi_byte == b && spi_hold == h, "R9 byte stable", spi_byte, b);
                end
                rx = 8'h00;
                if (tbytes.size() == 1 && tbytes[0] == 8'hD7)
                    rx = (polls < busyk) ? 8'h7F : 8'h80;
                spi_rx = rx;
                spi_ack = 1'b1;
                @(negedge clk);
                spi_ack = 1'b0;
                tbytes.push_back(b);
                lat = (lat + 1) % 3;
                if (!h) finish_txn(rx);
            end
        end
    end

    task automatic kick(input int pg, input int cnt, input int sel, input int gap, input int bk);
        int p = pg, c = cnt;
        while (c > 0) begin
            bit blk = (p % 8 == 0) && (c >= 8);
            logic [23:0] a = 24'(p << (8 + sel));
            expq.push_back({blk ? 8'h50 : 8'h81, a[23:16], a[15:8]});
            p += blk ? 8 : 1;
            c -= blk ? 8 : 1;
        end
        busyk = bk; exp_gap = gap; polls = 0; seen_cmd = 0;
        @(negedge clk);
        start_page = 16'(pg); page_count = 17'(cnt);
        page_shift_sel = 2'(sel); poll_gap = 16'(gap);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int cnt);
        while (!done) @(negedge clk);
        check(!busy, "R6 busy low with done", busy, 0);
        @(negedge clk);
        check(!done && !busy, "R6 done one cycle", done, 0);
        check(expq.size() == 0, "R5 all steps issued", expq.size(), 0);
        if (cnt > 0) check(polls == busyk + 1, "R4 final polls", polls, busyk + 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(!busy && !done && !spi_req, "R1 reset state", {busy, done, spi_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !spi_req, "R1 after reset", {busy, done, spi_req}, 0);

        kick(0, 8, 0, 3, 2);      wait_done(8);    // one block step
        kick(5, 12, 1, 0, 1);     wait_done(12);   // pages then block then page
        kick(3000, 3, 3, 1, 0);   wait_done(3);    // wide shift, ready at once
        kick(8, 7, 2, 2, 1);      wait_done(7);    // aligned but short: R2 pages only
        kick(5, 0, 0, 0, 0);      wait_done(0);    // zero count: R6

        // R7: start during a run is ignored
        kick(16, 16, 2, 2, 1);
        repeat (20) @(negedge clk);
        check(busy, "R7 busy at second start", busy, 1);
        start_page = 16'd1; page_count = 17'd1; poll_gap = 16'd7; page_shift_sel = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(16);
        repeat (5) @(negedge clk);
        check(!busy && !spi_req, "R7 no leftover run", {busy, spi_req}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule